// File: doc/BRIEF.md
# Programmable Chip Select Controller

This block turns processor bus accesses into four active-low external chip-select lines. Each select owns a fixed address window, which is placed by parameters and has a power-of-two size, and a small control register. The register holds an enable bit, a write-protect bit and a pin-level bit. When an access lands in the window of an enabled select, that select's line is pulled low for the cycle of the access. If the select is disabled, or the access is a write to a protected window, the block raises a transfer error acknowledge toward the processor and leaves the line unasserted.

A disabled select's line becomes a software-driven output that follows its pin-level bit. Select 0 is the exception: it idles high whenever it is disabled. Select 0 comes out of reset enabled so that a boot ROM can be fetched through it. The control registers sit in their own small address region on the same bus and take only full-word writes. Select and error outputs are combinational in the access cycle. Register updates take effect at the next clock edge.

Top module: `chip_select_ctrl`

## Requirements
- R1: Select i's window covers addresses WIN_BASE + i*2^WIN_LOG2 up to the next 2^WIN_LOG2 boundary. An enabled select drives its line low exactly in a cycle where bus_valid is high and bus_addr lies in its window, and high in every other cycle.
- R2: A write (bus_write=1) to the window of an enabled select whose write-protect bit is 1 raises tea and leaves that line high. A read of the same window asserts the line with no error.
- R3: With write-protect 0, a write to an enabled select's window asserts the line and raises no error.
- R4: Any valid access to the window of a disabled select raises tea and does not pull the line low.
- R5: While selects 1 to 3 are disabled, each line drives the level of its pin-level bit (0 low, 1 high) whatever the bus does.
- R6: After reset, the register read values are 0x3 for select 0, 0x2 for selects 1 and 2, and 0x0 for select 3. This means select 0 is enabled, the others are disabled, and select 3 drives low.
- R7: While select 0 is disabled, its line stays high regardless of its pin-level bit and of the bus.
- R8: A valid access outside every select window raises no tea and pulls no enabled line low.
- R9: Register k is at byte address REG_BASE + 4*k (k = 0..3). Bit 0 is enable, bit 1 is pin level, bit 2 is write protect, and all other bits read as 0. A write changes a register only when bus_word is 1; other writes leave it unchanged. Register accesses raise no tea.
- R10: tea and an asserted select never occur for the same access, and both fall back as soon as bus_valid drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_word | input | 1 | 1 when the access is a full 32-bit word |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data for register updates |
| bus_rdata | output | 32 | Register read data, 0 when not a register read |
| cs_n | output | 4 | Active-low chip-select lines, bit i for select i |
| tea | output | 1 | Transfer error acknowledge to the processor |

## Verification
Select lines, tea and register read data are combinational, so they are due in the same cycle as the access. The bench drives each access at the falling edge and samples about 2 ns later, which is before the next rising edge. A register write shows its effect only after the following rising edge. Each reconfiguration therefore holds its write for one full cycle before any dependent access is driven and checked. After every access, bus_valid is dropped and the lines are checked again to confirm that they return to idle levels.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int NSEL = 4;

  typedef struct packed {
    logic wp;
    logic pa;
    logic en;
  } sel_cfg_t;
endpackage

// File: rtl/cs_window_decode.sv
module cs_window_decode #(
  parameter int ADDR_W   = 16,
  parameter int NSEL     = 4,
  parameter int WIN_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0000,
  localparam int IDX_W   = $clog2(NSEL)
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   hit,
  output logic              reg_hit,
  output logic [IDX_W-1:0]  reg_idx
);
  localparam int TAG_W   = ADDR_W - WIN_LOG2;
  localparam int REG_LSB = IDX_W + 2;
  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_win
    assign hit[gi] = valid && (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG + TAG_W'(gi));
  end

  assign reg_hit = valid && (addr[ADDR_W-1:REG_LSB] == REG_BASE[ADDR_W-1:REG_LSB]);
  assign reg_idx = addr[REG_LSB-1:2];
endmodule

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs
  import cs_pkg::*;
#(
  parameter int NSEL = 4,
  parameter logic [NSEL-1:0] RST_EN = 4'b0001,
  parameter logic [NSEL-1:0] RST_PA = 4'b0111,
  localparam int IDX_W = $clog2(NSEL)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [2:0]            wr_bits,
  output sel_cfg_t [NSEL-1:0]   cfg
);
  for (genvar gi = 0; gi < NSEL; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[gi] <= '{wp: 1'b0, pa: RST_PA[gi], en: RST_EN[gi]};
      end else if (wr_en && wr_idx == IDX_W'(gi)) begin
        cfg[gi] <= '{wp: wr_bits[2], pa: wr_bits[1], en: wr_bits[0]};
      end
    end
  end
endmodule

// File: rtl/cs_pin_logic.sv
module cs_pin_logic
  import cs_pkg::*;
#(
  parameter int NSEL = 4
) (
  input  sel_cfg_t [NSEL-1:0] cfg,
  input  logic [NSEL-1:0]     hit,
  input  logic                write,
  output logic [NSEL-1:0]     cs_n,
  output logic                tea
);
  logic [NSEL-1:0] blocked;

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_pin
    assign blocked[gi] = hit[gi] && (!cfg[gi].en || (cfg[gi].wp && write));
    if (gi == 0) begin : g_boot
      assign cs_n[gi] = cfg[gi].en ? !(hit[gi] && !blocked[gi]) : 1'b1;
    end else begin : g_gpio
      assign cs_n[gi] = cfg[gi].en ? !(hit[gi] && !blocked[gi]) : cfg[gi].pa;
    end
  end

  assign tea = |blocked;
endmodule

// File: rtl/chip_select_ctrl.sv
module chip_select_ctrl
  import cs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0000,
  parameter logic [NSEL-1:0]   RST_EN   = 4'b0001,
  parameter logic [NSEL-1:0]   RST_PA   = 4'b0111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NSEL-1:0]   cs_n,
  output logic              tea
);
  localparam int IDX_W = $clog2(NSEL);

  logic [NSEL-1:0]     hit;
  logic                reg_hit;
  logic [IDX_W-1:0]    reg_idx;
  sel_cfg_t [NSEL-1:0] cfg;

  cs_window_decode #(
    .ADDR_W(ADDR_W), .NSEL(NSEL), .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(WIN_BASE), .REG_BASE(REG_BASE)
  ) u_dec (
    .valid(bus_valid), .addr(bus_addr),
    .hit(hit), .reg_hit(reg_hit), .reg_idx(reg_idx)
  );

  cs_ctrl_regs #(
    .NSEL(NSEL), .RST_EN(RST_EN), .RST_PA(RST_PA)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_hit && bus_write && bus_word),
    .wr_idx(reg_idx), .wr_bits(bus_wdata[2:0]), .cfg(cfg)
  );

  cs_pin_logic #(.NSEL(NSEL)) u_pins (
    .cfg(cfg), .hit(hit), .write(bus_write), .cs_n(cs_n), .tea(tea)
  );

  always_comb begin
    bus_rdata = '0;
    if (reg_hit && !bus_write) bus_rdata[2:0] = cfg[reg_idx];
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker
  import cs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000,
  parameter logic [NSEL-1:0]   RST_EN   = 4'b0001
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_valid,
  input logic                bus_write,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [NSEL-1:0]     cs_n,
  input logic                tea,
  input sel_cfg_t [NSEL-1:0] cfg
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  logic [NSEL-1:0] in_win;
  logic [NSEL-1:0] en_vec;

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_chk
    assign in_win[gi] = bus_valid &&
      (bus_addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2] + TAG_W'(gi));
    assign en_vec[gi] = cfg[gi].en;

    AST_WP_BLOCK: assert property (@(posedge clk) disable iff (rst)
      (bus_write && in_win[gi] && cfg[gi].en && cfg[gi].wp) |-> (tea && cs_n[gi])); // R2
    AST_OFF_ERR: assert property (@(posedge clk) disable iff (rst)
      (in_win[gi] && !cfg[gi].en) |-> tea); // R4
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (cfg[gi].en && !in_win[gi]) |-> cs_n[gi]); // R1
    if (gi > 0) begin : g_gp
      AST_GPIO_LVL: assert property (@(posedge clk) disable iff (rst)
        !cfg[gi].en |-> (cs_n[gi] == cfg[gi].pa)); // R5
    end
  end

  AST_CS0_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg[0].en |-> cs_n[0]); // R7
  AST_EXCL: assert property (@(posedge clk) disable iff (rst)
    tea |-> (&(cs_n | ~en_vec))); // R10
  AST_NO_WIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_win == '0) |-> !tea); // R8
  AST_RST_DEF: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_vec == RST_EN)); // R6
endmodule

bind chip_select_ctrl cs_checker #(
  .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE), .RST_EN(RST_EN)
) u_cs_checker (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .cs_n(cs_n), .tea(tea), .cfg(cfg)
);

// File: tb/test_chip_select_ctrl.sv
module test_chip_select_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {write, addr, expected cs_n, expected tea} with reset configuration
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 16'h8004, 4'b0110, 1'b0},
    {1'b1, 16'h8FFC, 4'b0110, 1'b0},
    {1'b0, 16'h9000, 4'b0111, 1'b1},
    {1'b1, 16'hB010, 4'b0111, 1'b1},
    {1'b0, 16'hC000, 4'b0111, 1'b0},
    {1'b0, 16'h7FFC, 4'b0111, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic bus_valid = 0, bus_write = 0, bus_word = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cs_n;
  logic        tea;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_select_ctrl i_chip_select_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cs_n(cs_n), .tea(tea)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive an access at the falling edge, sample 2 ns later
  task automatic access(input logic wr, input logic word, input logic [15:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_word = word; bus_addr = a; bus_wdata = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    #2;
  endtask

  task automatic reg_write(input int k, input logic [31:0] d, input logic word);
    access(1'b1, word, 16'(4*k), d);
    check("R9 reg write tea", {31'b0, tea}, 0);
    idle();
  endtask

  task automatic reg_read(input int k, input logic [31:0] exp, input string req);
    access(1'b0, 1'b1, 16'(4*k), 0);
    check(req, bus_rdata, exp);
    check("R9 reg read tea", {31'b0, tea}, 0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    check("R6 reset cs_n", {28'b0, cs_n}, 32'h7);
    check("R6 reset tea", {31'b0, tea}, 0);
    reg_read(0, 32'h3, "R6 reg0");
    reg_read(1, 32'h2, "R6 reg1");
    reg_read(2, 32'h2, "R6 reg2");
    reg_read(3, 32'h0, "R6 reg3");

    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][21], 1'b1, VEC[i][20:5], 0);
      check("R1/R4/R8 vector cs_n", {28'b0, cs_n}, {28'b0, VEC[i][4:1]});
      check("R4/R8 vector tea", {31'b0, tea}, {31'b0, VEC[i][0]});
      if (tea) check("R10 exclusive", {28'b0, cs_n}, 32'h7);
      idle();
      check("R10 release", {27'b0, tea, cs_n}, 32'h7);
    end

    // enable select 1
    reg_write(1, 32'h1, 1'b1);
    access(1'b0, 1'b1, 16'h9000, 0);
    check("R1 cs1 enabled", {27'b0, tea, cs_n}, 32'h5);
    idle();
    // partial write ignored
    reg_write(2, 32'h1, 1'b0);
    reg_read(2, 32'h2, "R9 partial write ignored");
    // upper bits read zero, pin level high for select 3
    reg_write(3, 32'hFFFF_FFF2, 1'b1);
    reg_read(3, 32'h2, "R9 upper bits zero");
    check("R5 cs3 gpio high", {31'b0, cs_n[3]}, 1);
    // write protect on select 1
    reg_write(1, 32'h5, 1'b1);
    access(1'b1, 1'b1, 16'h9100, 32'hAA);
    check("R2 wp write", {27'b0, tea, cs_n}, 32'h1F);
    idle();
    access(1'b0, 1'b1, 16'h9100, 0);
    check("R2 wp read", {27'b0, tea, cs_n}, 32'hD);
    idle();
    reg_write(1, 32'h1, 1'b1);
    access(1'b1, 1'b1, 16'h9100, 32'hAA);
    check("R3 unprotected write", {27'b0, tea, cs_n}, 32'hD);
    idle();
    // disable select 0 with pin level 0
    reg_write(0, 32'h0, 1'b1);
    check("R7 cs0 idle high", {31'b0, cs_n[0]}, 1);
    access(1'b0, 1'b1, 16'h8000, 0);
    check("R4 cs0 disabled access", {27'b0, tea, cs_n}, 32'h1F);
    check("R7 cs0 high on access", {31'b0, cs_n[0]}, 1);
    idle();
    // select 2 driven low as output
    reg_write(2, 32'h0, 1'b1);
    check("R5 cs2 gpio low", {28'b0, cs_n}, 32'hB);
    access(1'b1, 1'b1, 16'hA000, 0);
    check("R4 cs2 disabled write", {27'b0, tea, cs_n}, 32'h1B);
    idle();
    access(1'b0, 1'b1, 16'hF000, 0);
    check("R8 outside windows", {27'b0, tea, cs_n}, 32'hB);
    idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule